// File: doc/BRIEF.md
# Four-Entry UART Receive Byte Buffer

This block is a small first-in first-out store of received bytes. It sits between a byte-level serial receiver and the host register interface. The receiver offers bytes or break events. The host empties the buffer by reading the data register. The buffer keeps the two status flags that the controller exports: data available and buffer full.

A push into a buffer that already holds four bytes does not drop the new byte. It overwrites the newest stored byte instead, so the most recent arrival always survives. A break event stores a zero byte and raises a one-cycle break pulse, which the controller's interrupt logic collects. A receiver-reset command flushes the buffer synchronously. The buffer also tells the receiver when it may deliver a byte.

Top module: `rx_fifo4`

## Requirements
- R1: After reset the buffer is empty: `data_ready`=0, `buf_full`=0, `pop_data`=0x00, `break_pulse`=0.
- R2: Bytes leave in the order they arrived. `pop_data` shows the oldest stored byte combinationally while `data_ready`=1. A pop advances the buffer at the clock edge.
- R3: A push sets `data_ready` in the cycle after the edge that takes it. `buf_full` is 1 exactly when four bytes are held.
- R4: A push into a full buffer with no pop in the same cycle replaces the newest (fourth) byte. The three older bytes are unchanged and `buf_full` stays 1.
- R5: A pop clears `buf_full`. `data_ready` clears when the last byte is popped.
- R6: While the buffer is empty, `pop_data` is 0x00, and a pop changes no state.
- R7: A break event (`push_break`=1) stores 0x00, taking priority over `push_data`. `break_pulse` is 1 for exactly the one cycle after the edge that takes the break.
- R8: `can_accept` = `rx_enable` AND NOT `buf_full`.
- R9: A flush empties the buffer and clears `data_ready` and `buf_full`. It takes priority over a push or a pop in the same cycle.
- R10: A push and a pop in the same cycle on a non-empty buffer do the pop first and then store the pushed byte at the new tail, so the count is unchanged. On an empty buffer the pop is ignored and the push is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Receiver delivers `push_data` this cycle |
| push_data | input | 8 | Received byte |
| push_break | input | 1 | Break event: store 0x00 and pulse `break_pulse` |
| pop | input | 1 | Host reads the data register this cycle |
| flush | input | 1 | Receiver-reset command: empty the buffer |
| rx_enable | input | 1 | Receiver enabled |
| pop_data | output | 8 | Oldest stored byte, 0x00 when empty |
| data_ready | output | 1 | At least one byte stored |
| buf_full | output | 1 | Four bytes stored |
| can_accept | output | 1 | Receiver may deliver a byte |
| break_pulse | output | 1 | One-cycle break indication |

## Verification
A push and a pop can land in the same cycle. So can a flush and either of them. The bench raises these inputs together on a partly filled buffer, a full buffer and an empty buffer. It then judges the outcome at the ports: it drains the buffer and compares each byte and the flags against the pop-first, then push order. For a flush it checks that the buffer comes out empty, whatever push or pop came with it.

// File: rtl/rx_fifo4.sv
module rx_fifo4 #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             push_break,
  input  logic             pop,
  input  logic             flush,
  input  logic             rx_enable,
  output logic [WIDTH-1:0] pop_data,
  output logic             data_ready,
  output logic             buf_full,
  output logic             can_accept,
  output logic             break_pulse
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem  [DEPTH];
  logic [WIDTH-1:0] nmem [DEPTH];
  logic [CW-1:0]    count, ncnt;
  logic             do_push, do_pop;
  logic [WIDTH-1:0] wdata;

  assign do_push    = push_valid | push_break;
  assign do_pop     = pop & (count != '0);
  assign wdata      = push_break ? '0 : push_data;
  assign data_ready = (count != '0);
  assign buf_full   = (count == CW'(DEPTH));
  assign can_accept = rx_enable & ~buf_full;
  assign pop_data   = data_ready ? mem[0] : '0;

  always_comb begin
    nmem = mem;
    ncnt = count;
    if (do_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) nmem[i] = mem[i+1];
      nmem[DEPTH-1] = '0;
      ncnt = count - 1'b1;
    end
    if (do_push) begin
      if (ncnt == CW'(DEPTH)) begin
        nmem[DEPTH-1] = wdata;
      end else begin
        nmem[ncnt[IW-1:0]] = wdata;
        ncnt = ncnt + 1'b1;
      end
    end
    if (flush) ncnt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count       <= '0;
      break_pulse <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      count       <= ncnt;
      break_pulse <= push_break;
      for (int i = 0; i < DEPTH; i++) mem[i] <= nmem[i];
    end
  end
endmodule

// File: rtl/rx_fifo4_chk.sv
module rx_fifo4_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             push_break,
  input logic             pop,
  input logic             flush,
  input logic             rx_enable,
  input logic [WIDTH-1:0] pop_data,
  input logic             data_ready,
  input logic             buf_full,
  input logic             can_accept,
  input logic             break_pulse
);
  assert_full_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> data_ready);

  assert_push_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((push_valid | push_break) && !flush) |=> data_ready);

  assert_overwrite_keeps_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && push_valid && !pop && !flush) |=> buf_full);

  assert_pop_clears_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && pop && !push_valid && !push_break && !flush) |=> !buf_full && data_ready);

  assert_empty_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> (pop_data == '0));

  assert_empty_pop_stays_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && pop && !push_valid && !push_break) |=> !data_ready);

  assert_break_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_break && !flush) |=> break_pulse && data_ready);

  assert_accept_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    can_accept |-> (rx_enable && !buf_full));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!data_ready && !buf_full));

  assert_swap_keeps_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && pop && push_valid && !flush) |=> data_ready && (buf_full == $past(buf_full)));
endmodule

bind rx_fifo4 rx_fifo4_chk #(.WIDTH(WIDTH)) chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_break(push_break),
  .pop(pop), .flush(flush), .rx_enable(rx_enable), .pop_data(pop_data),
  .data_ready(data_ready), .buf_full(buf_full), .can_accept(can_accept),
  .break_pulse(break_pulse)
);

// File: tb/tb_rx_fifo4.sv
module tb_rx_fifo4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0, push_break = 1'b0, pop = 1'b0, flush = 1'b0;
  logic       rx_enable = 1'b1;
  logic [7:0] push_data = '0;
  logic [7:0] pop_data;
  logic       data_ready, buf_full, can_accept, break_pulse;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  rx_fifo4 dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_break(push_break), .pop(pop), .flush(flush), .rx_enable(rx_enable),
    .pop_data(pop_data), .data_ready(data_ready), .buf_full(buf_full),
    .can_accept(can_accept), .break_pulse(break_pulse)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  task automatic push(input logic [7:0] d);
    push_valid = 1'b1; push_data = d;
    step();
    push_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string req);
    check(req, pop_data, exp);
    pop = 1'b1;
    step();
    pop = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 ready", {7'b0, data_ready}, 8'h00);
    check("R1 full", {7'b0, buf_full}, 8'h00);
    check("R1 data", pop_data, 8'h00);
    check("R1 break", {7'b0, break_pulse}, 8'h00);
    check("R8 accept", {7'b0, can_accept}, 8'h01);
  endtask

  task automatic t_order;
    push(8'hA1); push(8'hB2); push(8'hC3);
    check("R3 ready", {7'b0, data_ready}, 8'h01);
    check("R3 not full", {7'b0, buf_full}, 8'h00);
    pop_expect(8'hA1, "R2 first");
    pop_expect(8'hB2, "R2 second");
    check("R5 ready kept", {7'b0, data_ready}, 8'h01);
    pop_expect(8'hC3, "R2 third");
    check("R5 ready cleared", {7'b0, data_ready}, 8'h00);
  endtask

  task automatic t_overwrite;
    push(8'h10); push(8'h11); push(8'h12); push(8'h13);
    check("R3 full", {7'b0, buf_full}, 8'h01);
    check("R8 blocked", {7'b0, can_accept}, 8'h00);
    push(8'h99);
    check("R4 still full", {7'b0, buf_full}, 8'h01);
    pop_expect(8'h10, "R4 oldest");
    check("R5 full cleared", {7'b0, buf_full}, 8'h00);
    check("R8 reopened", {7'b0, can_accept}, 8'h01);
    pop_expect(8'h11, "R4 second");
    pop_expect(8'h12, "R4 third");
    pop_expect(8'h99, "R4 replaced newest");
    check("R5 empty", {7'b0, data_ready}, 8'h00);
  endtask

  task automatic t_empty_pop;
    pop_expect(8'h00, "R6 empty read");
    check("R6 still empty", {7'b0, data_ready}, 8'h00);
    push(8'h05);
    pop_expect(8'h05, "R6 no side effect");
    check("R6 empty again", {7'b0, data_ready}, 8'h00);
  endtask

  task automatic t_break;
    push(8'h21);
    check("R7 no pulse", {7'b0, break_pulse}, 8'h00);
    push_break = 1'b1; push_valid = 1'b1; push_data = 8'h77;
    step();
    push_break = 1'b0; push_valid = 1'b0;
    check("R7 pulse", {7'b0, break_pulse}, 8'h01);
    step();
    check("R7 pulse ends", {7'b0, break_pulse}, 8'h00);
    pop_expect(8'h21, "R7 prior byte");
    check("R7 break entry held", {7'b0, data_ready}, 8'h01);
    pop_expect(8'h00, "R7 zero byte");
    check("R7 drained", {7'b0, data_ready}, 8'h00);
  endtask

  task automatic t_same_cycle;
    push(8'h01); push(8'h02);
    check("R10 head", pop_data, 8'h01);
    pop = 1'b1; push_valid = 1'b1; push_data = 8'h03;
    step();
    pop = 1'b0; push_valid = 1'b0;
    check("R10 not full", {7'b0, buf_full}, 8'h00);
    pop_expect(8'h02, "R10 after swap 1");
    pop_expect(8'h03, "R10 after swap 2");
    check("R10 count kept", {7'b0, data_ready}, 8'h00);
    push(8'h05); push(8'h06); push(8'h07); push(8'h08);
    pop = 1'b1; push_valid = 1'b1; push_data = 8'h09;
    step();
    pop = 1'b0; push_valid = 1'b0;
    check("R10 full swap", {7'b0, buf_full}, 8'h01);
    pop_expect(8'h06, "R10 full order 1");
    pop_expect(8'h07, "R10 full order 2");
    pop_expect(8'h08, "R10 full order 3");
    pop_expect(8'h09, "R10 full order 4");
    pop = 1'b1; push_valid = 1'b1; push_data = 8'h44;
    step();
    pop = 1'b0; push_valid = 1'b0;
    check("R10 empty swap ready", {7'b0, data_ready}, 8'h01);
    pop_expect(8'h44, "R10 empty swap data");
  endtask

  task automatic t_flush;
    push(8'h31); push(8'h32);
    flush = 1'b1; push_valid = 1'b1; push_data = 8'h33; pop = 1'b1;
    step();
    flush = 1'b0; push_valid = 1'b0; pop = 1'b0;
    check("R9 ready", {7'b0, data_ready}, 8'h00);
    check("R9 data", pop_data, 8'h00);
    push(8'h41); push(8'h42); push(8'h43); push(8'h44);
    flush = 1'b1;
    step();
    flush = 1'b0;
    check("R9 full cleared", {7'b0, buf_full}, 8'h00);
    check("R9 accept", {7'b0, can_accept}, 8'h01);
    push(8'h55);
    pop_expect(8'h55, "R9 fresh after flush");
    rx_enable = 1'b0;
    #1;
    check("R8 disabled", {7'b0, can_accept}, 8'h00);
    rx_enable = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_order();
    t_overwrite();
    t_empty_pop();
    t_break();
    t_same_cycle();
    t_flush();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule